// File: doc/BRIEF.md
# Timed Seven-Segment Result Sequencer

This block drives a four-digit, time-multiplexed seven-segment display that presents the outcome of arithmetic and list instructions. In arithmetic mode it shows the two operands and the result together. In list mode, used for sorted results and for register dumps, it shows the element count on the leftmost digit. It steps through up to seven list values on the rightmost digit, one per display period. Unused digits are dark.

The digits are lit one at a time in a fixed round-robin order. Each digit holds for a parameterised number of clocks, which gives a refresh of about 1 kHz per digit at the default setting. A `start` pulse restarts the period timer and the list position. Release from reset has the same effect as a start. After the last value has had its full period, it stays on the display until the next start. The inputs are taken live from the ports. The block computes no results and does not debounce its inputs.

Top module: `resultSeqDisplay`

## Requirements
- R1: While `rstN` is low, `anodeN` is all ones and `segN` is all ones. Leaving reset acts like a `start` pulse taken on the first clock edge. After release the rightmost digit (digit 0) is lit first.
- R2: At most one bit of `anodeN` is low at a time, and a low bit lights that digit. Digit k is lit by `anodeN[k]`; bit 3 is the leftmost digit and bit 0 the rightmost. Digits are visited in the order 0, 1, 2, 3, 0, and so on. Each digit is visited for `CLK_PER_SLOT` clocks, so after n clock edges since reset release digit (n / `CLK_PER_SLOT`) mod 4 is selected.
- R3: A shown 4-bit value v appears as its hexadecimal glyph on active-low `segN`. Segment a is bit 0 and segment g is bit 6. The active-high patterns (g..a) for v = 0..F are 3F 06 5B 4F 66 6D 7D 07 7F 6F 77 7C 39 5E 79 71.
- R4: When `mode` = 01 (arithmetic), digit 3 shows `opA`, digit 2 shows `opB`, digit 0 shows `res`, and digit 1 is blank.
- R5: When `mode` = 10 (list), digit 3 shows `count` as a hex glyph, and digits 2 and 1 are blank.
- R6: In list mode, digit 0 shows list entry i, where entry i occupies `listVals[4i+3:4i]`. The position i is the number of whole `CLK_PER_SEC` periods since the last start, so each entry stays on for exactly `CLK_PER_SEC` clocks.
- R7: Once the position reaches `count`-1 it stays there, keeping the last entry on digit 0, until the next start.
- R8: A `start` pulse that is high at a clock edge sets the position to 0 and restarts the period timer, whatever the current position or timer phase.
- R9: When `mode` is 00 or 11, every digit is blank. In list mode with `count` = 0, digit 0 is blank.
- R10: While a blank digit's slot is in progress, `anodeN` is all ones and `segN` is all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset; also blanks the outputs |
| start | input | 1 | One-clock pulse that restarts the list sequence |
| mode | input | 2 | 00 off, 01 arithmetic, 10 list, 11 off |
| opA | input | VAL_W | Arithmetic operand A |
| opB | input | VAL_W | Arithmetic operand B |
| res | input | VAL_W | Arithmetic result |
| count | input | CNT_W | Number of list entries (0..LIST_LEN) |
| listVals | input | LIST_LEN*VAL_W | Packed list, entry i at bits [VAL_W*i +: VAL_W] |
| anodeN | output | DIGITS | Active-low digit enables, bit DIGITS-1 leftmost |
| segN | output | 7 | Active-low segments, bit 0 = a to bit 6 = g |

## Verification
The bench builds the block with `CLK_PER_SEC` = 40 and `CLK_PER_SLOT` = 3. With these values a complete seven-entry sequence, including the hold on the last entry, takes a few hundred clocks. Every count from 0 to 7 can therefore be run to completion. The bench also covers all sixteen glyphs and restarts at arbitrary timer phases. Every clock it compares the selected digit and segment pattern against a model built from edge counts since reset and since the last start.

// File: rtl/segseq_pkg.sv
package segseq_pkg;

  typedef enum logic [1:0] {
    MODE_OFF   = 2'b00,
    MODE_ARITH = 2'b01,
    MODE_LIST  = 2'b10,
    MODE_IDLE  = 2'b11
  } dispMode_e;

  // strobes from the timing control to the datapath
  typedef struct packed {
    logic slotAdv;   // move to next digit
    logic secAdv;    // one display period elapsed
    logic restart;   // restart list position
  } seqStrobe_t;

  // active-high hex glyph, bit 0 = segment a ... bit 6 = segment g
  function automatic logic [6:0] hexGlyph(input logic [3:0] v);
    logic [6:0] g;
    case (v)
      4'h0: g = 7'h3F;
      4'h1: g = 7'h06;
      4'h2: g = 7'h5B;
      4'h3: g = 7'h4F;
      4'h4: g = 7'h66;
      4'h5: g = 7'h6D;
      4'h6: g = 7'h7D;
      4'h7: g = 7'h07;
      4'h8: g = 7'h7F;
      4'h9: g = 7'h6F;
      4'hA: g = 7'h77;
      4'hB: g = 7'h7C;
      4'hC: g = 7'h39;
      4'hD: g = 7'h5E;
      4'hE: g = 7'h79;
      default: g = 7'h71;
    endcase
    return g;
  endfunction

endpackage

// File: rtl/seqTimer.sv
module seqTimer
  import segseq_pkg::*;
#(
  parameter int CLK_PER_SLOT = 12_500,
  parameter int CLK_PER_SEC  = 50_000_000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  output seqStrobe_t strobe
);

  localparam int SLOT_W = (CLK_PER_SLOT > 1) ? $clog2(CLK_PER_SLOT) : 1;
  localparam int SEC_W  = (CLK_PER_SEC > 1) ? $clog2(CLK_PER_SEC) : 1;
  localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(CLK_PER_SLOT - 1);
  localparam logic [SEC_W-1:0]  SEC_LAST  = SEC_W'(CLK_PER_SEC - 1);

  logic [SLOT_W-1:0] slotCnt;
  logic [SEC_W-1:0]  secCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      slotCnt <= '0;
    end else if (slotCnt == SLOT_LAST) begin
      slotCnt <= '0;
    end else begin
      slotCnt <= slotCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      secCnt <= '0;
    end else if (start || secCnt == SEC_LAST) begin
      secCnt <= '0;
    end else begin
      secCnt <= secCnt + 1'b1;
    end
  end

  always_comb begin
    strobe.slotAdv = (slotCnt == SLOT_LAST);
    strobe.secAdv  = (secCnt == SEC_LAST) && !start;
    strobe.restart = start;
  end

  // R8
  sec_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    start |=> (secCnt == '0));

  // R6
  sec_adv_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.secAdv |=> (secCnt == '0));

endmodule

// File: rtl/seqDatapath.sv
module seqDatapath
  import segseq_pkg::*;
#(
  parameter int VAL_W    = 4,
  parameter int LIST_LEN = 7,
  parameter int DIGITS   = 4,
  parameter int CNT_W    = $clog2(LIST_LEN + 1)
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  seqStrobe_t                strobe,
  input  logic [1:0]                mode,
  input  logic [VAL_W-1:0]          opA,
  input  logic [VAL_W-1:0]          opB,
  input  logic [VAL_W-1:0]          res,
  input  logic [CNT_W-1:0]          count,
  input  logic [LIST_LEN*VAL_W-1:0] listVals,
  output logic [DIGITS-1:0]         anodeN,
  output logic [6:0]                segN
);

  localparam int DSEL_W = (DIGITS > 1) ? $clog2(DIGITS) : 1;
  localparam logic [DSEL_W-1:0] DSEL_LAST = DSEL_W'(DIGITS - 1);
  localparam logic [DSEL_W-1:0] DSEL_B    = DSEL_W'(DIGITS - 2);

  logic [DSEL_W-1:0] digitSel;
  logic [CNT_W-1:0]  listIdx;
  logic [CNT_W:0]    nextIdx;
  logic              advance;
  logic [VAL_W-1:0]  listArr [LIST_LEN];
  logic [VAL_W-1:0]  curListVal;
  logic [VAL_W-1:0]  shownVal;
  logic              showDigit;
  dispMode_e         modeE;

  // unpack the list entries
  for (genvar g = 0; g < LIST_LEN; g++) begin : gUnpack
    assign listArr[g] = listVals[g*VAL_W +: VAL_W];
  end

  // digit scan position
  always_ff @(posedge clk) begin
    if (!rstN) begin
      digitSel <= '0;
    end else if (strobe.slotAdv) begin
      digitSel <= (digitSel == DSEL_LAST) ? '0 : digitSel + 1'b1;
    end
  end

  assign nextIdx = {1'b0, listIdx} + 1'b1;
  assign advance = (nextIdx < {1'b0, count});

  // list position, saturating at count-1
  always_ff @(posedge clk) begin
    if (!rstN) begin
      listIdx <= '0;
    end else if (strobe.restart) begin
      listIdx <= '0;
    end else if (strobe.secAdv && advance) begin
      listIdx <= nextIdx[CNT_W-1:0];
    end
  end

  always_comb begin
    if (int'(listIdx) < LIST_LEN) curListVal = listArr[listIdx];
    else                          curListVal = '0;
  end

  // digit content selection
  always_comb begin
    modeE     = dispMode_e'(mode);
    showDigit = 1'b0;
    shownVal  = '0;
    case (modeE)
      MODE_ARITH: begin
        if (digitSel == DSEL_LAST) begin
          showDigit = 1'b1;
          shownVal  = opA;
        end else if (digitSel == DSEL_B) begin
          showDigit = 1'b1;
          shownVal  = opB;
        end else if (digitSel == '0) begin
          showDigit = 1'b1;
          shownVal  = res;
        end
      end
      MODE_LIST: begin
        if (digitSel == DSEL_LAST) begin
          showDigit = 1'b1;
          shownVal  = VAL_W'(count);
        end else if (digitSel == '0 && count != '0) begin
          showDigit = 1'b1;
          shownVal  = curListVal;
        end
      end
      default: begin
        showDigit = 1'b0;
      end
    endcase
  end

  always_comb begin
    if (showDigit && rstN) begin
      anodeN = ~(DIGITS'(1) << digitSel);
      segN   = ~hexGlyph(4'(shownVal));
    end else begin
      anodeN = '1;
      segN   = '1;
    end
  end

  // R2
  anode_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $countones(~anodeN) <= 1);

  // R2
  digit_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.slotAdv |=> (digitSel == (($past(digitSel) == DSEL_LAST) ? '0 : $past(digitSel) + 1'b1)));

  // R10
  blank_seg_chk: assert property (@(posedge clk) disable iff (!rstN)
    (anodeN == '1) |-> (segN == '1));

  // R8
  idx_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.restart |=> (listIdx == '0));

  // R7
  idx_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.restart && !(strobe.secAdv && advance)) |=> $stable(listIdx));

  // R6
  idx_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.secAdv && !strobe.restart && advance) |=> (listIdx == $past(listIdx) + 1'b1));

endmodule

// File: rtl/resultSeqDisplay.sv
module resultSeqDisplay
  import segseq_pkg::*;
#(
  parameter int CLK_PER_SEC  = 50_000_000,
  parameter int CLK_PER_SLOT = 12_500,
  parameter int LIST_LEN     = 7,
  parameter int VAL_W        = 4,
  parameter int DIGITS       = 4,
  localparam int CNT_W       = $clog2(LIST_LEN + 1)
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      start,
  input  logic [1:0]                mode,
  input  logic [VAL_W-1:0]          opA,
  input  logic [VAL_W-1:0]          opB,
  input  logic [VAL_W-1:0]          res,
  input  logic [CNT_W-1:0]          count,
  input  logic [LIST_LEN*VAL_W-1:0] listVals,
  output logic [DIGITS-1:0]         anodeN,
  output logic [6:0]                segN
);

  seqStrobe_t strobe;

  seqTimer #(
    .CLK_PER_SLOT(CLK_PER_SLOT),
    .CLK_PER_SEC (CLK_PER_SEC)
  ) u_timer (
    .clk   (clk),
    .rstN  (rstN),
    .start (start),
    .strobe(strobe)
  );

  seqDatapath #(
    .VAL_W   (VAL_W),
    .LIST_LEN(LIST_LEN),
    .DIGITS  (DIGITS),
    .CNT_W   (CNT_W)
  ) u_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .mode    (mode),
    .opA     (opA),
    .opB     (opB),
    .res     (res),
    .count   (count),
    .listVals(listVals),
    .anodeN  (anodeN),
    .segN    (segN)
  );

endmodule

// File: tb/resultSeqDisplay_bench.sv
module resultSeqDisplay_bench;

  localparam int SEC  = 40;
  localparam int SLOT = 3;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  mode = 2'b10;
  logic [3:0]  opA = '0, opB = '0, res = '0;
  logic [2:0]  count = 3'd7;
  logic [27:0] listVals = '0;
  logic [3:0]  anodeN;
  logic [6:0]  segN;

  int checks = 0;
  int errors = 0;
  int edgesN = 0;
  int startEdge = 0;
  int cyc = 0;

  logic [6:0] glyphTab [16];

  always #10 clk = ~clk;

  resultSeqDisplay #(
    .CLK_PER_SEC (SEC),
    .CLK_PER_SLOT(SLOT)
  ) u_resultSeqDisplay (
    .clk(clk), .rstN(rstN), .start(start), .mode(mode),
    .opA(opA), .opB(opB), .res(res), .count(count),
    .listVals(listVals), .anodeN(anodeN), .segN(segN)
  );

  // reference edge counting
  always @(posedge clk) begin
    if (rstN) begin
      edgesN = edgesN + 1;
      if (start) startEdge = edgesN;
    end
  end

  // watchdog
  always @(posedge clk) begin
    cyc = cyc + 1;
    if (cyc > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog: run did not finish, actual %0d cycles expected under 150000", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic expectNow(output logic [3:0] eAn, output logic [6:0] eSeg);
    int d, idx, c;
    bit show;
    logic [3:0] v;
    d = (edgesN / SLOT) % 4;
    c = int'(count);
    idx = (edgesN - startEdge) / SEC;
    if (c > 0 && idx > c - 1) idx = c - 1;
    show = 1'b0;
    v = '0;
    if (!rstN) show = 1'b0;
    else if (mode == 2'b01) begin
      if (d == 3) begin show = 1'b1; v = opA; end
      else if (d == 2) begin show = 1'b1; v = opB; end
      else if (d == 0) begin show = 1'b1; v = res; end
    end else if (mode == 2'b10) begin
      if (d == 3) begin show = 1'b1; v = {1'b0, count}; end
      else if (d == 0 && c > 0) begin show = 1'b1; v = listVals[idx*4 +: 4]; end
    end
    if (show) begin
      eAn  = ~(4'b0001 << d);
      eSeg = ~glyphTab[v];
    end else begin
      eAn  = 4'hF;
      eSeg = 7'h7F;
    end
  endtask

  task automatic checkNow(input string tag);
    logic [3:0] eAn;
    logic [6:0] eSeg;
    expectNow(eAn, eSeg);
    checks = checks + 1;
    if (anodeN !== eAn || segN !== eSeg) begin
      errors = errors + 1;
      $display("FAIL %s (R2 R10 scan): anodeN=%b segN=%b expected anodeN=%b segN=%b at edge %0d",
               tag, anodeN, segN, eAn, eSeg, edgesN);
    end
  endtask

  task automatic runCycles(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      checkNow(tag);
    end
  endtask

  task automatic pulseStart(input string tag);
    start = 1'b1;
    runCycles(1, tag);
    start = 1'b0;
  endtask

  task automatic fillList(input int base);
    for (int i = 0; i < 7; i++) listVals[i*4 +: 4] = 4'(base + 3*i);
  endtask

  initial begin
    glyphTab = '{7'h3F, 7'h06, 7'h5B, 7'h4F, 7'h66, 7'h6D, 7'h7D, 7'h07,
                 7'h7F, 7'h6F, 7'h77, 7'h7C, 7'h39, 7'h5E, 7'h79, 7'h71};
    fillList(2);

    // R1: outputs blank under reset
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      checks = checks + 1;
      if (anodeN !== 4'hF || segN !== 7'h7F) begin
        errors = errors + 1;
        $display("FAIL R1 reset: anodeN=%b segN=%b expected 1111 1111111", anodeN, segN);
      end
    end
    rstN = 1'b1;
    // R1: release acts as a start; whole sequence without a start pulse
    runCycles(SEC * 8 + 5, "R1");

    // R3: every glyph on every shown digit
    mode = 2'b01;
    for (int v = 0; v < 16; v++) begin
      opA = 4'(v); opB = 4'(15 - v); res = 4'(v ^ 5);
      runCycles(12, "R3");
    end

    // R4: arithmetic patterns
    opA = 4'h9; opB = 4'hE; res = 4'h7;
    runCycles(24, "R4");
    opA = 4'h0; opB = 4'h0; res = 4'hF;
    runCycles(24, "R4");

    // R5 R6 R7: each count run past its end
    mode = 2'b10;
    for (int c = 1; c <= 7; c++) begin
      count = 3'(c);
      fillList(c * 5);
      pulseStart("R5 R6 R7");
      runCycles((c + 2) * SEC, "R5 R6 R7");
    end

    // R8: restarts at several timer phases
    count = 3'd7;
    fillList(1);
    pulseStart("R8");
    runCycles(97, "R8");
    pulseStart("R8");
    runCycles(13, "R8");
    pulseStart("R8");
    pulseStart("R8");
    runCycles(SEC * 3 - 1, "R8");
    pulseStart("R8");
    runCycles(SEC * 8, "R8");

    // R9: count zero, off modes
    count = 3'd0;
    pulseStart("R9");
    runCycles(SEC + 4, "R9");
    mode = 2'b00;
    runCycles(20, "R9");
    mode = 2'b11;
    runCycles(20, "R9");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule